// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a serial receiver's deserializer and a host. Each completed character arrives with a push strobe, eight data bits and three error flags: a break flag (the line stayed low for a whole frame), a framing flag (no valid stop bit) and a parity flag. The block stores the character and its own flags together as one queue entry. The host reads characters through a receive-holding-register read strobe, and it reads an 8-bit line status word through a separate status read strobe.

The low error bits of the status word show only the flags of the entry at the head of the queue, which is the next character the host will get. The host therefore reads the status word first and then the data register to tie an error to its character. A counter of stored entries that carry any flag drives a summary bit. That bit stays set until no flagged entry remains. When a character arrives while the queue is full, it is dropped and an overrun bit is set. Two transmit-side status inputs are registered into the word. All state changes become visible on the outputs one clock after the strobe that causes them.

Top module: `rx_status_fifo`

## Requirements
- R1: While reset is held and right after it, `lsr_o` reads 8'h60 when both transmit inputs are high: bits 6 and 5 are 1 and all other bits are 0.
- R2: Accepted characters are returned in arrival order. `lsr_o[0]` is 1 exactly when at least one character is stored, and `rhr_data_o` shows the head character's data whenever `lsr_o[0]` is 1.
- R3: `lsr_o[4]`, `lsr_o[3]` and `lsr_o[2]` show the break, framing and parity flag of the head entry. All three read 0 when the queue is empty.
- R4: A cycle with `rhr_rd_i` high on a non-empty queue removes the head entry. From the next cycle, `rhr_data_o` and `lsr_o[4:2]` follow the new head.
- R5: `lsr_o[7]` is 1 while any stored entry has at least one flag set, and 0 once none remains. This holds across cycles that push and pop at the same time.
- R6: A push while `DEPTH` entries are stored and no pop takes place in the same cycle discards the incoming character, leaves the stored entries unchanged and sets `lsr_o[1]`.
- R7: A cycle with `lsr_rd_i` high clears `lsr_o[1]` from the next cycle, unless an overrun happens in that same cycle, in which case the bit stays 1.
- R8: A push and a pop in the same cycle on a full queue are both carried out: the head leaves, the new character is stored, and no overrun is flagged.
- R9: A pop strobe on an empty queue has no effect: `lsr_o[0]`, `lsr_o[7]` and `lsr_o[4:2]` stay 0.
- R10: One cycle after the inputs are sampled, `lsr_o[5]` equals `thr_empty_i`, and `lsr_o[6]` equals `thr_empty_i` AND `tsr_empty_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Strobe: a completed character is offered |
| push_data_i | input | 8 | Character data |
| push_brk_i | input | 1 | Break flag of the offered character |
| push_fe_i | input | 1 | Framing-error flag of the offered character |
| push_pe_i | input | 1 | Parity-error flag of the offered character |
| rhr_rd_i | input | 1 | Strobe: host reads and pops the head character |
| lsr_rd_i | input | 1 | Strobe: host reads the status word |
| thr_empty_i | input | 1 | Transmit hold path is empty |
| tsr_empty_i | input | 1 | Transmit shift register is empty |
| rhr_data_o | output | 8 | Head character data, 0 when the queue is empty |
| lsr_o | output | 8 | Line status word |

## Verification
The queue is tested with four kinds of traffic. A short burst of clean characters checks ordering and the data-available bit. A run of characters with each flag set alone checks that bits 4:2 follow the head as it moves and that the summary bit lasts until the last flagged entry leaves. A fill to full depth with scattered errors, followed by extra pushes, separates a discarded character from a stored one and checks when the overrun bit sets and clears, including a status read in the same cycle as an overrun. Cycles that push and pop together, both half-full and full, separate correct error counting from double counting. Pops on an empty queue and combinations of the transmit inputs complete the tests.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_ent_t;

  localparam int unsigned ENT_W = $bits(rx_ent_t);

  // status word bit positions
  localparam int unsigned ST_ERRSUM = 7;
  localparam int unsigned ST_TXIDLE = 6;
  localparam int unsigned ST_THRE   = 5;
  localparam int unsigned ST_BRK    = 4;
  localparam int unsigned ST_FE     = 3;
  localparam int unsigned ST_PE     = 2;
  localparam int unsigned ST_OVR    = 1;
  localparam int unsigned ST_AVAIL  = 0;
endpackage

// File: rtl/rsf_mem.sv
module rsf_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 11,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual port, registered read, forwarding on same-address write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end
endmodule

// File: rtl/rsf_ctrl.sv
module rsf_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          push_err_i,
  input  logic          pop_req_i,
  input  logic          head_err_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          ovr_evt_o,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] err_cnt_o
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ, err_cnt;
  logic          pop_ok, push_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_A) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok    = pop_req_i && (occ != '0);
  assign push_ok   = push_i && ((occ != FULL_V) || pop_ok);
  assign ovr_evt_o = push_i && !push_ok;
  assign we_o      = push_ok;
  assign waddr_o   = wr_ptr;
  assign raddr_o   = pop_ok ? nxt(rd_ptr) : rd_ptr;
  assign occ_o     = occ;
  assign err_cnt_o = err_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      err_cnt <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      occ     <= occ + CW'(push_ok) - CW'(pop_ok);
      err_cnt <= err_cnt + CW'(push_ok && push_err_i) - CW'(pop_ok && head_err_i);
    end
  end
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int unsigned DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push_i,
  input  logic [7:0] push_data_i,
  input  logic       push_brk_i,
  input  logic       push_fe_i,
  input  logic       push_pe_i,
  input  logic       rhr_rd_i,
  input  logic       lsr_rd_i,
  input  logic       thr_empty_i,
  input  logic       tsr_empty_i,
  output logic [7:0] rhr_data_o,
  output logic [7:0] lsr_o
);
  import rsf_pkg::*;

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_ent_t       wr_ent, head;
  logic          we, ovr_evt, head_err, avail;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] occ, err_cnt;
  logic          ovr_q, thre_q, txidle_q;

  assign wr_ent = '{brk: push_brk_i, fe: push_fe_i, pe: push_pe_i, data: push_data_i};
  assign head_err = head.brk | head.fe | head.pe;

  rsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .push_i(push_i), .push_err_i(push_brk_i | push_fe_i | push_pe_i),
    .pop_req_i(rhr_rd_i), .head_err_i(head_err),
    .we_o(we), .waddr_o(waddr), .raddr_o(raddr), .ovr_evt_o(ovr_evt),
    .occ_o(occ), .err_cnt_o(err_cnt)
  );

  rsf_mem #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_ent),
    .raddr(raddr), .rdata(head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q    <= 1'b0;
      thre_q   <= 1'b1;
      txidle_q <= 1'b1;
    end else begin
      if (ovr_evt)       ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
      thre_q   <= thr_empty_i;
      txidle_q <= thr_empty_i & tsr_empty_i;
    end
  end

  assign avail      = (occ != '0);
  assign rhr_data_o = avail ? head.data : '0;

  always_comb begin
    lsr_o            = '0;
    lsr_o[ST_ERRSUM] = (err_cnt != '0);
    lsr_o[ST_TXIDLE] = txidle_q;
    lsr_o[ST_THRE]   = thre_q;
    lsr_o[ST_BRK]    = avail & head.brk;
    lsr_o[ST_FE]     = avail & head.fe;
    lsr_o[ST_PE]     = avail & head.pe;
    lsr_o[ST_OVR]    = ovr_q;
    lsr_o[ST_AVAIL]  = avail;
  end
endmodule

// File: rtl/rsf_chk.sv
module rsf_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          rhr_rd_i,
  input logic          lsr_rd_i,
  input logic [7:0]    lsr_o,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] err_cnt
);
  logic full_push;
  assign full_push = push_i && (occ == CW'(DEPTH)) && !rhr_rd_i;

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    full_push |=> lsr_o[1]);
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full_push |=> (occ == CW'(DEPTH)));
  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd_i && !full_push) |=> !lsr_o[1]);
  // R3
  empty_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !lsr_o[0] |-> (lsr_o[4:2] == 3'b000 && !lsr_o[7]));
  // R5
  err_bound_chk: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= occ);
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && rhr_rd_i && !push_i) |=> (occ == '0));
  // R10
  tx_pair_chk: assert property (@(posedge clk) disable iff (rst)
    lsr_o[6] |-> lsr_o[5]);
  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
endmodule

bind rx_status_fifo rsf_chk #(.DEPTH(DEPTH)) u_rsf_chk (
  .clk(clk), .rst(rst), .push_i(push_i), .rhr_rd_i(rhr_rd_i),
  .lsr_rd_i(lsr_rd_i), .lsr_o(lsr_o), .occ(occ), .err_cnt(err_cnt)
);

// File: tb/test_rx_status_fifo.sv
module test_rx_status_fifo;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_i = 1'b0, rhr_rd_i = 1'b0, lsr_rd_i = 1'b0;
  logic [7:0] push_data_i = '0;
  logic       push_brk_i = 1'b0, push_fe_i = 1'b0, push_pe_i = 1'b0;
  logic       thr_empty_i = 1'b1, tsr_empty_i = 1'b1;
  logic [7:0] rhr_data_o, lsr_o;

  rx_status_fifo #(.DEPTH(DEPTH)) i_rx_status_fifo (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // scoreboard: {brk, fe, pe, data}
  logic [10:0] exp_q[$];
  bit m_ovr = 1'b0, m_thre = 1'b1, m_idle = 1'b1;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_lsr();
    logic [7:0] v = '0;
    foreach (exp_q[i]) if (exp_q[i][10:8] != 3'b000) v[7] = 1'b1;
    v[6] = m_idle;
    v[5] = m_thre;
    if (exp_q.size() > 0) v[4:2] = exp_q[0][10:8];
    v[1] = m_ovr;
    v[0] = (exp_q.size() > 0);
    return v;
  endfunction

  // driver + monitor: one cycle of stimulus, then compare outputs with the model
  task automatic op(input string tag, input bit psh, input logic [7:0] d,
                    input logic [2:0] f, input bit rd, input bit lr);
    bit pop_ok, push_ok;
    @(negedge clk);
    push_i = psh; push_data_i = d; {push_brk_i, push_fe_i, push_pe_i} = f;
    rhr_rd_i = rd; lsr_rd_i = lr;
    #2;
    if (lr) chk({tag, " status value read"}, lsr_o, model_lsr());
    if (rd && exp_q.size() > 0) chk({tag, " popped data"}, rhr_data_o, exp_q[0][7:0]);
    @(posedge clk);
    pop_ok  = rd && exp_q.size() > 0;
    push_ok = psh && (exp_q.size() < DEPTH || pop_ok);
    if (pop_ok)  void'(exp_q.pop_front());
    if (push_ok) exp_q.push_back({f, d});
    if (psh && !push_ok) m_ovr = 1'b1;
    else if (lr)         m_ovr = 1'b0;
    m_thre = thr_empty_i;
    m_idle = thr_empty_i & tsr_empty_i;
    #5;
    push_i = 1'b0; rhr_rd_i = 1'b0; lsr_rd_i = 1'b0;
    chk({tag, " status"}, lsr_o, model_lsr());
    chk({tag, " head data"}, rhr_data_o, (exp_q.size() > 0) ? exp_q[0][7:0] : 8'h00);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 chk("R1 in reset", lsr_o, 8'h60);
    @(negedge clk) rst = 1'b0;
    #2 chk("R1 after reset", lsr_o, 8'h60);

    // clean burst then one flag each
    op("R2 push", 1, 8'h41, 3'b000, 0, 0);
    op("R2 push", 1, 8'h42, 3'b000, 0, 0);
    op("R3 brk", 1, 8'h43, 3'b100, 0, 0);
    op("R3 fe",  1, 8'h44, 3'b010, 0, 0);
    op("R3 pe",  1, 8'h45, 3'b001, 0, 1);
    for (int i = 0; i < 5; i++) op("R4 R5 drain", 0, 8'h00, 3'b000, 1, 1);
    op("R9 empty pop", 0, 8'h00, 3'b000, 1, 0);
    op("R9 empty pop again", 0, 8'h00, 3'b000, 1, 0);

    // simultaneous push and pop with errors
    op("R5 push pe", 1, 8'h50, 3'b001, 0, 0);
    op("R5 push+pop", 1, 8'h51, 3'b000, 1, 0);
    op("R5 push+pop err", 1, 8'h52, 3'b110, 1, 0);
    op("R5 pop", 0, 8'h00, 3'b000, 1, 0);
    op("R9 push on empty with pop", 1, 8'h53, 3'b000, 1, 0);
    op("R5 pop last", 0, 8'h00, 3'b000, 1, 0);

    // fill to full depth
    for (int i = 0; i < DEPTH; i++)
      op("R2 fill", 1, 8'(i + 8'h80), (i % 7 == 3) ? 3'b010 : 3'b000, 0, 0);
    op("R6 overrun", 1, 8'hEE, 3'b100, 0, 0);
    op("R7 status read clears", 0, 8'h00, 3'b000, 0, 1);
    op("R7 overrun wins over read", 1, 8'hEF, 3'b000, 0, 1);
    op("R7 read clears", 0, 8'h00, 3'b000, 0, 1);
    op("R8 push+pop at full", 1, 8'h11, 3'b001, 1, 0);
    for (int i = 0; i < DEPTH; i++) op("R6 R4 drain kept", 0, 8'h00, 3'b000, 1, 0);

    // transmit status inputs
    thr_empty_i = 1'b1; tsr_empty_i = 1'b0;
    op("R10 hold empty only", 0, 8'h00, 3'b000, 0, 0);
    thr_empty_i = 1'b0; tsr_empty_i = 1'b0;
    op("R10 both busy", 0, 8'h00, 3'b000, 0, 0);
    thr_empty_i = 1'b0; tsr_empty_i = 1'b1;
    op("R10 shift empty only", 0, 8'h00, 3'b000, 0, 0);
    thr_empty_i = 1'b1; tsr_empty_i = 1'b1;
    op("R10 both empty", 0, 8'h00, 3'b000, 0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule